// File: doc/BRIEF.md
# Nested Opcode Byte Decoder

This block turns a single 8-bit opcode byte into everything an instruction sequencer needs before it fetches operands. It reports which instruction the byte names, which registers are read and written, how the operand is addressed, whether the instruction is followed by a 16-bit word (3 bytes in total) or stands alone (1 byte), and whether the byte is illegal. The decode is purely combinational, so all outputs follow the input byte in the same cycle.

The byte is cut into a 3-bit class field (bits 7:5), a 2-bit register field (bits 4:3) and a 3-bit operand field (bits 2:0). Classes one to seven are the two-operand instructions. Class zero opens a secondary group that the register field selects: zero-operand instructions, conditional and unconditional jumps, bitwise invert, and one reserved slot. Encodings that would store into a constant are illegal, except the all-ones byte, which is reported as an expansion prefix so a later stage can switch to a second opcode map.

Top module: `opdec_top`

## Requirements
- R1: Class field values 1 to 5 decode to or, and, cmp, sub and add, on kind bits 0 to 4. Class 6 is a load into a register, on kind bit 5. For classes 1 to 6 the destination register is the register field, and the mode output equals the operand field.
- R2: For classes 1 to 6, an operand field of 0 to 3 means a register source, and the source register output equals operand field bits 1:0. Operand values 4, 5, 6 and 7 mean register-indirect, indexed, direct and immediate, and the source register output is 0.
- R3: For classes 1 to 6 the length output is 3 when the operand field is 5, 6 or 7, and 1 otherwise. The length output always gives the byte count, either 1 or 3.
- R4: Class 7 with operand field 4, 5 or 6 is a store, on kind bit 6. Its source register is the register field, its mode is the operand field, its destination output is 0, and its length is 3 for modes 5 and 6 and 1 for mode 4.
- R5: Class 7 with operand field 0 to 3, or with operand field 7, is illegal. Byte 0xFF is the one exception.
- R6: Byte 0xFF raises the prefix output with the illegal output low, no kind bit set and length 1.
- R7: Bytes 0x08 to 0x0E are jumps, on kind bit 8. Their condition output equals the operand field (0 unconditional, 1 above, 2 above-or-equal, 3 below, 4 below-or-equal, 5 equal, 6 not-equal) and their length is 3. Byte 0x0F is illegal.
- R8: Bytes 0x10 to 0x16 are bitwise invert, on kind bit 7. Mode equals the operand field. For operand field 0 to 3, both register outputs equal the operand field bits 1:0. Length follows the rule in R3. Byte 0x17 is illegal.
- R9: Bytes 0x05, 0x06 and 0x07 are halt, input and output, on kind bits 9, 10 and 11, each with length 1. Bytes 0x00 to 0x04 are illegal.
- R10: Bytes 0x18 to 0x1F, the reserved slot of the class-zero group, are illegal.
- R11: For every byte, exactly one of these holds: one kind bit is set, the illegal output is high, or the prefix output is high. An illegal byte drives no kind bit, length 1, and zero on the register, mode and condition outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 8 | Opcode byte to decode |
| kind_o | output | 12 | One-hot instruction kind (bit map in R1, R4, R7, R8, R9) |
| dst_reg_o | output | 2 | Destination register select |
| src_reg_o | output | 2 | Source register select |
| mode_o | output | 3 | Operand addressing mode (operand field value) |
| len_o | output | 2 | Instruction length in bytes, 1 or 3 |
| jcond_o | output | 3 | Jump condition code |
| illegal_o | output | 1 | Byte is not a valid instruction |
| prefix_o | output | 1 | Byte is the expansion prefix 0xFF |

## Verification
Assertions check on every input change that exactly one of a kind bit, illegal or prefix is active, that illegal bytes leave every other output quiet, that jumps are 3 bytes and zero-operand instructions 1 byte, that stores use only memory modes, and that a 3-byte length never goes with an illegal byte or the prefix. Only the bench scenarios can show that each particular byte maps to the right kind, registers, mode and condition: the worked encodings, the boundaries of the store, invert and jump groups, the reserved slot, and the prefix exception. A full sweep of all 256 bytes compares the outputs against a model built from the requirements.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    localparam int OP_W   = 8;
    localparam int CLS_W  = 3;
    localparam int REG_W  = 2;
    localparam int MODE_W = 3;
    localparam int LEN_W  = 2;
    localparam int KIND_N = 12;

    localparam int CLS_LSB  = REG_W + MODE_W;
    localparam int REG_LSB  = MODE_W;

    // kind bit positions
    localparam int K_OR    = 0;
    localparam int K_AND   = 1;
    localparam int K_CMP   = 2;
    localparam int K_SUB   = 3;
    localparam int K_ADD   = 4;
    localparam int K_LOAD  = 5;
    localparam int K_STORE = 6;
    localparam int K_INV   = 7;
    localparam int K_JUMP  = 8;
    localparam int K_HALT  = 9;
    localparam int K_GET   = 10;
    localparam int K_PUT   = 11;

    // operand field encodings
    localparam logic [MODE_W-1:0] M_IND = 3'b100;
    localparam logic [MODE_W-1:0] M_IDX = 3'b101;
    localparam logic [MODE_W-1:0] M_DIR = 3'b110;
    localparam logic [MODE_W-1:0] M_IMM = 3'b111;

    // class-zero sub-groups selected by the register field
    localparam logic [REG_W-1:0] G_ZERO = 2'b00;
    localparam logic [REG_W-1:0] G_JUMP = 2'b01;
    localparam logic [REG_W-1:0] G_INV  = 2'b10;

    localparam logic [CLS_W-1:0] CLS_EXT   = 3'd0;
    localparam logic [CLS_W-1:0] CLS_STORE = 3'd7;

    localparam logic [LEN_W-1:0] LEN_ONE   = 2'd1;
    localparam logic [LEN_W-1:0] LEN_THREE = 2'd3;

    typedef struct packed {
        logic [KIND_N-1:0] kind;
        logic [REG_W-1:0]  dst;
        logic [REG_W-1:0]  src;
        logic [MODE_W-1:0] mode;
        logic [LEN_W-1:0]  len;
        logic [MODE_W-1:0] jcond;
        logic              illegal;
        logic              prefix;
    } dec_t;

    localparam dec_t DEC_BAD = '{
        kind:    '0,
        dst:     '0,
        src:     '0,
        mode:    '0,
        len:     LEN_ONE,
        jcond:   '0,
        illegal: 1'b1,
        prefix:  1'b0
    };

    // true when the operand needs a trailing 16-bit word
    function automatic logic needs_word(input logic [MODE_W-1:0] m);
        return (m == M_IDX) || (m == M_DIR) || (m == M_IMM);
    endfunction

    function automatic logic is_reg_mode(input logic [MODE_W-1:0] m);
        return m[MODE_W-1] == 1'b0;
    endfunction

endpackage

// File: rtl/opdec_core_group.sv
// Decodes classes 1..7: two-operand ALU ops, load and store.
module opdec_core_group
    import opdec_pkg::*;
(
    input  logic [CLS_W-1:0]  cls_i,
    input  logic [REG_W-1:0]  rr_i,
    input  logic [MODE_W-1:0] mmm_i,
    output dec_t              dec_o
);

    dec_t dec_d;

    always_comb begin
        dec_d = DEC_BAD;
        if (cls_i == CLS_STORE) begin
            if (mmm_i == M_IND || mmm_i == M_IDX || mmm_i == M_DIR) begin
                dec_d.illegal        = 1'b0;
                dec_d.kind[K_STORE]  = 1'b1;
                dec_d.src            = rr_i;
                dec_d.mode           = mmm_i;
                dec_d.len            = needs_word(mmm_i) ? LEN_THREE : LEN_ONE;
            end else if (rr_i == '1 && mmm_i == M_IMM) begin
                dec_d.illegal = 1'b0;
                dec_d.prefix  = 1'b1;
            end
        end else if (cls_i != CLS_EXT) begin
            dec_d.illegal = 1'b0;
            // classes 1..6 map onto kind bits 0..5 in order
            dec_d.kind[int'(cls_i) - 1] = 1'b1;
            dec_d.dst  = rr_i;
            dec_d.src  = is_reg_mode(mmm_i) ? mmm_i[REG_W-1:0] : '0;
            dec_d.mode = mmm_i;
            dec_d.len  = needs_word(mmm_i) ? LEN_THREE : LEN_ONE;
        end
    end

    assign dec_o = dec_d;

endmodule

// File: rtl/opdec_ext_group.sv
// Decodes class 0: zero-operand group, jumps, invert, reserved slot.
module opdec_ext_group
    import opdec_pkg::*;
(
    input  logic [REG_W-1:0]  rr_i,
    input  logic [MODE_W-1:0] mmm_i,
    output dec_t              dec_o
);

    dec_t dec_d;

    always_comb begin
        dec_d = DEC_BAD;
        unique case (rr_i)
            G_ZERO: begin
                dec_d.illegal = 1'b0;
                case (mmm_i)
                    3'd5:    dec_d.kind[K_HALT] = 1'b1;
                    3'd6:    dec_d.kind[K_GET]  = 1'b1;
                    3'd7:    dec_d.kind[K_PUT]  = 1'b1;
                    default: dec_d.illegal      = 1'b1;
                endcase
            end
            G_JUMP: begin
                if (mmm_i != M_IMM) begin
                    dec_d.illegal       = 1'b0;
                    dec_d.kind[K_JUMP]  = 1'b1;
                    dec_d.jcond         = mmm_i;
                    dec_d.len           = LEN_THREE;
                end
            end
            G_INV: begin
                if (mmm_i != M_IMM) begin
                    dec_d.illegal      = 1'b0;
                    dec_d.kind[K_INV]  = 1'b1;
                    dec_d.mode         = mmm_i;
                    if (is_reg_mode(mmm_i)) begin
                        dec_d.dst = mmm_i[REG_W-1:0];
                        dec_d.src = mmm_i[REG_W-1:0];
                    end
                    dec_d.len = needs_word(mmm_i) ? LEN_THREE : LEN_ONE;
                end
            end
            default: ; // reserved slot stays illegal
        endcase
    end

    assign dec_o = dec_d;

endmodule

// File: rtl/opdec_top.sv
module opdec_top
    import opdec_pkg::*;
(
    input  logic [OP_W-1:0]   opcode_i,
    output logic [KIND_N-1:0] kind_o,
    output logic [REG_W-1:0]  dst_reg_o,
    output logic [REG_W-1:0]  src_reg_o,
    output logic [MODE_W-1:0] mode_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [MODE_W-1:0] jcond_o,
    output logic              illegal_o,
    output logic              prefix_o
);

    logic [CLS_W-1:0]  cls;
    logic [REG_W-1:0]  rr;
    logic [MODE_W-1:0] mmm;
    dec_t              core_dec;
    dec_t              ext_dec;
    dec_t              dec_d;

    assign cls = opcode_i[OP_W-1:CLS_LSB];
    assign rr  = opcode_i[CLS_LSB-1:REG_LSB];
    assign mmm = opcode_i[REG_LSB-1:0];

    opdec_core_group i_core (
        .cls_i (cls),
        .rr_i  (rr),
        .mmm_i (mmm),
        .dec_o (core_dec)
    );

    opdec_ext_group i_ext (
        .rr_i  (rr),
        .mmm_i (mmm),
        .dec_o (ext_dec)
    );

    always_comb begin
        dec_d = (cls == CLS_EXT) ? ext_dec : core_dec;
    end

    assign kind_o    = dec_d.kind;
    assign dst_reg_o = dec_d.dst;
    assign src_reg_o = dec_d.src;
    assign mode_o    = dec_d.mode;
    assign len_o     = dec_d.len;
    assign jcond_o   = dec_d.jcond;
    assign illegal_o = dec_d.illegal;
    assign prefix_o  = dec_d.prefix;

    // Output-level consistency checks across the two group decoders.
    always_comb begin
        a_r11_one_outcome: assert (($countones(kind_o) + 32'(illegal_o) + 32'(prefix_o)) == 1)
            else $error("R11: outcome not unique for %h", opcode_i);
        a_r11_illegal_quiet: assert (!illegal_o || (kind_o == '0 && len_o == LEN_ONE
                                     && dst_reg_o == '0 && src_reg_o == '0
                                     && mode_o == '0 && jcond_o == '0))
            else $error("R11: illegal byte %h drives outputs", opcode_i);
        a_r7_jump_len: assert (!kind_o[K_JUMP] || len_o == LEN_THREE)
            else $error("R7: jump length wrong for %h", opcode_i);
        a_r9_zero_op_len: assert (!(kind_o[K_HALT] || kind_o[K_GET] || kind_o[K_PUT]) || len_o == LEN_ONE)
            else $error("R9: zero-operand length wrong for %h", opcode_i);
        a_r4_store_mode: assert (!kind_o[K_STORE] || mode_o == M_IND || mode_o == M_IDX || mode_o == M_DIR)
            else $error("R4: store with non-memory mode for %h", opcode_i);
        a_r3_len_values: assert ((len_o == LEN_ONE) || (len_o == LEN_THREE && !illegal_o && !prefix_o))
            else $error("R3: bad length for %h", opcode_i);
        a_r6_prefix_quiet: assert (!prefix_o || (kind_o == '0 && len_o == LEN_ONE))
            else $error("R6: prefix drives outputs for %h", opcode_i);
    end

endmodule

// File: tb/test_opdec_top.sv
module test_opdec_top;

    logic        clk = 1'b0;
    logic [7:0]  opcode;
    logic [11:0] kind;
    logic [1:0]  dst, src;
    logic [2:0]  mode, jc;
    logic [1:0]  len;
    logic        ill, pre;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    opdec_top i_opdec_top (
        .opcode_i  (opcode),
        .kind_o    (kind),
        .dst_reg_o (dst),
        .src_reg_o (src),
        .mode_o    (mode),
        .len_o     (len),
        .jcond_o   (jc),
        .illegal_o (ill),
        .prefix_o  (pre)
    );

    // apply one byte at a rising edge, compare all outputs at the falling edge
    task automatic chk(input logic [7:0] op, input logic [11:0] e_kind,
                       input logic [1:0] e_dst, input logic [1:0] e_src,
                       input logic [2:0] e_mode, input logic [1:0] e_len,
                       input logic [2:0] e_jc, input logic e_ill, input logic e_pre,
                       input string tag);
        @(posedge clk);
        opcode = op;
        @(negedge clk);
        checks++;
        if (kind !== e_kind || dst !== e_dst || src !== e_src || mode !== e_mode ||
            len !== e_len || jc !== e_jc || ill !== e_ill || pre !== e_pre) begin
            errors++;
            $display("FAIL %s op=%h actual kind=%h dst=%0d src=%0d mode=%0d len=%0d jc=%0d ill=%b pre=%b expected kind=%h dst=%0d src=%0d mode=%0d len=%0d jc=%0d ill=%b pre=%b",
                     tag, op, kind, dst, src, mode, len, jc, ill, pre,
                     e_kind, e_dst, e_src, e_mode, e_len, e_jc, e_ill, e_pre);
        end
    endtask

    task automatic chk_bad(input logic [7:0] op, input string tag);
        chk(op, 12'h000, 2'd0, 2'd0, 3'd0, 2'd1, 3'd0, 1'b1, 1'b0, tag);
    endtask

    task automatic t_alu_classes;
        chk(8'h21, 12'h001, 2'd0, 2'd1, 3'd1, 2'd1, 3'd0, 1'b0, 1'b0, "R1 or bx,ax");
        chk(8'h4C, 12'h002, 2'd1, 2'd0, 3'd4, 2'd1, 3'd0, 1'b0, 1'b0, "R1 and [bx],bx");
        chk(8'h7A, 12'h004, 2'd3, 2'd2, 3'd2, 2'd1, 3'd0, 1'b0, 1'b0, "R1 cmp cx,dx");
        chk(8'h9F, 12'h008, 2'd3, 2'd0, 3'd7, 2'd3, 3'd0, 1'b0, 1'b0, "R1 sub imm,dx");
        chk(8'hBA, 12'h010, 2'd3, 2'd2, 3'd2, 2'd1, 3'd0, 1'b0, 1'b0, "R2 add cx,dx");
        chk(8'hC1, 12'h020, 2'd0, 2'd1, 3'd1, 2'd1, 3'd0, 1'b0, 1'b0, "R2 load bx,ax");
        chk(8'hDB, 12'h020, 2'd3, 2'd3, 3'd3, 2'd1, 3'd0, 1'b0, 1'b0, "R2 load dx,dx");
    endtask

    task automatic t_lengths;
        chk(8'hA7, 12'h010, 2'd0, 2'd0, 3'd7, 2'd3, 3'd0, 1'b0, 1'b0, "R3 add imm");
        chk(8'hB5, 12'h010, 2'd2, 2'd0, 3'd5, 2'd3, 3'd0, 1'b0, 1'b0, "R3 add idx");
        chk(8'hA6, 12'h010, 2'd0, 2'd0, 3'd6, 2'd3, 3'd0, 1'b0, 1'b0, "R3 add dir");
        chk(8'hC6, 12'h020, 2'd0, 2'd0, 3'd6, 2'd3, 3'd0, 1'b0, 1'b0, "R3 load dir");
        chk(8'hAC, 12'h010, 2'd1, 2'd0, 3'd4, 2'd1, 3'd0, 1'b0, 1'b0, "R3 add ind is 1 byte");
    endtask

    task automatic t_store;
        chk(8'hE4, 12'h040, 2'd0, 2'd0, 3'd4, 2'd1, 3'd0, 1'b0, 1'b0, "R4 store ax,[bx]");
        chk(8'hF5, 12'h040, 2'd0, 2'd2, 3'd5, 2'd3, 3'd0, 1'b0, 1'b0, "R4 store cx,idx");
        chk(8'hFE, 12'h040, 2'd0, 2'd3, 3'd6, 2'd3, 3'd0, 1'b0, 1'b0, "R4 store dx,dir");
        chk_bad(8'hE0, "R5 store to reg");
        chk_bad(8'hFB, "R5 store to reg dx");
        chk_bad(8'hE7, "R5 store to const");
        chk_bad(8'hEF, "R5 store to const");
        chk_bad(8'hF7, "R5 store to const");
    endtask

    task automatic t_prefix;
        chk(8'hFF, 12'h000, 2'd0, 2'd0, 3'd0, 2'd1, 3'd0, 1'b0, 1'b1, "R6 prefix");
    endtask

    task automatic t_jumps;
        for (int i = 0; i < 7; i++)
            chk(8'h08 + 8'(i), 12'h100, 2'd0, 2'd0, 3'd0, 2'd3, 3'(i), 1'b0, 1'b0, "R7 jump");
        chk_bad(8'h0F, "R7 unused jump slot");
    endtask

    task automatic t_invert;
        chk(8'h10, 12'h080, 2'd0, 2'd0, 3'd0, 2'd1, 3'd0, 1'b0, 1'b0, "R8 invert ax");
        chk(8'h13, 12'h080, 2'd3, 2'd3, 3'd3, 2'd1, 3'd0, 1'b0, 1'b0, "R8 invert dx");
        chk(8'h14, 12'h080, 2'd0, 2'd0, 3'd4, 2'd1, 3'd0, 1'b0, 1'b0, "R8 invert [bx]");
        chk(8'h15, 12'h080, 2'd0, 2'd0, 3'd5, 2'd3, 3'd0, 1'b0, 1'b0, "R8 invert idx");
        chk(8'h16, 12'h080, 2'd0, 2'd0, 3'd6, 2'd3, 3'd0, 1'b0, 1'b0, "R8 invert dir");
        chk_bad(8'h17, "R8 invert const");
    endtask

    task automatic t_zero_op;
        chk(8'h05, 12'h200, 2'd0, 2'd0, 3'd0, 2'd1, 3'd0, 1'b0, 1'b0, "R9 halt");
        chk(8'h06, 12'h400, 2'd0, 2'd0, 3'd0, 2'd1, 3'd0, 1'b0, 1'b0, "R9 get");
        chk(8'h07, 12'h800, 2'd0, 2'd0, 3'd0, 2'd1, 3'd0, 1'b0, 1'b0, "R9 put");
        for (int i = 0; i < 5; i++) chk_bad(8'(i), "R9 undefined zero-op");
    endtask

    task automatic t_reserved;
        for (int i = 8'h18; i <= 8'h1F; i++) chk_bad(8'(i), "R10 reserved group");
    endtask

    // Model built from the requirement text: walk byte ranges.
    task automatic t_sweep;
        for (int b = 0; b < 256; b++) begin
            logic [11:0] k; logic [1:0] d, s, l; logic [2:0] md, j; logic il, pf;
            logic [2:0] hi, lo; logic [1:0] mid;
            hi = 3'(b >> 5); mid = 2'((b >> 3) & 3); lo = 3'(b & 7);
            k = 0; d = 0; s = 0; md = 0; l = 1; j = 0; il = 1; pf = 0;
            if (hi >= 1 && hi <= 6) begin
                il = 0; k = 12'(1 << (hi - 1)); d = mid; md = lo;
                s = (lo < 4) ? lo[1:0] : 2'd0;
                l = (lo >= 5) ? 2'd3 : 2'd1;
            end else if (b == 8'hFF) begin
                il = 0; pf = 1;
            end else if (hi == 7 && lo >= 4 && lo <= 6) begin
                il = 0; k = 12'h040; s = mid; md = lo; l = (lo >= 5) ? 2'd3 : 2'd1;
            end else if (b >= 5 && b <= 7) begin
                il = 0; k = 12'(1 << (9 + b - 5));
            end else if (b >= 8 && b <= 14) begin
                il = 0; k = 12'h100; j = 3'(b - 8); l = 3;
            end else if (b >= 16 && b <= 22) begin
                il = 0; k = 12'h080; md = lo; l = (lo >= 5) ? 2'd3 : 2'd1;
                if (lo < 4) begin d = lo[1:0]; s = lo[1:0]; end
            end
            chk(8'(b), k, d, s, md, l, j, il, pf, "R11 sweep");
        end
    endtask

    initial begin
        opcode = 8'h00;
        repeat (2) @(posedge clk);
        t_alu_classes;
        t_lengths;
        t_store;
        t_prefix;
        t_jumps;
        t_invert;
        t_zero_op;
        t_reserved;
        t_sweep;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule